// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block receives configuration for a dual-channel frequency synthesizer over three slow wires: serial data, serial clock and load strobe. All three are brought into the system clock domain, and their edges are detected there. While the strobe is low, each rising edge of the serial clock shifts one data bit into a 21-bit frame, most significant bit first. The strobe's rising edge then copies the frame into one of four holding registers. The four low bits of the frame, which arrive last, choose the register.

The holding registers drive decoded fields to the rest of the synthesizer:
- two 17-bit main divide ratios, one per channel;
- a 12-bit reference divide ratio with its select bit;
- a test bit;
- four general-purpose pin settings;
- a two-bit lock-pin source select;
- a charge-pump current select bit per channel;
- a run bit per channel.

A run bit of 0 keeps its channel in power save. The port is write-only and cannot be read back. The sampling clock is assumed to be several times faster than the serial timing: at least 20 ns setup and hold, 50 ns clock high and low, and a strobe of at least 1 µs.

Top module: `serprog_top`

## Requirements
- R1: After reset, both main ratios are 1024, the reference ratio is 6, and every other output is 0, so both channels start in power save.
- R2: Each rising serial-clock edge taken while the strobe is low shifts in one bit, MSB first. After 21 bits, frame bit 20 is the first bit sent and bits [3:0] are the address.
- R3: Address 0 writes the control fields: pin settings from bits [7:4], lock-pin select from [9:8], charge-pump select from [11:10] (bit 10 for channel 1), and run bits from [13:12] (bit 12 for channel 1). Bits [20:14] are ignored.
- R4: Address 1 writes bits [20:4] into the channel-1 main ratio.
- R5: Address 3 writes bits [20:4] into the channel-2 main ratio.
- R6: Address 2 writes the reference ratio from bits [15:4], the reference select from bit 16 and the test bit from bit 17. Bits [20:18] are ignored.
- R7: A frame whose address is 4 to 15 changes no output.
- R8: A write happens only on a rising edge of the strobe, and it changes only the register that the address selects.
- R9: Serial-clock edges taken while the strobe is high do not shift the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system sampling clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| sdata_i | input | 1 | serial data line |
| sclk_i | input | 1 | serial clock line |
| sload_i | input | 1 | load strobe line |
| main1_o | output | 17 | channel-1 main divide ratio |
| main2_o | output | 17 | channel-2 main divide ratio |
| ref_div_o | output | 12 | reference divide ratio |
| ref_sel_o | output | 1 | reference select bit |
| test_o | output | 1 | test bit |
| pin_o | output | 4 | general-purpose pin settings |
| lock_sel_o | output | 2 | lock-pin source select |
| cp_hi_o | output | 2 | charge-pump current select per channel |
| run_o | output | 2 | per-channel run bits (0 = power save) |

## Verification
If the frame is wrong, for example a lost bit, a bit shifted while the strobe is high, or a misaligned address nibble, the error stays inside until the next strobe edge. At that edge it shows up either as a wrong field or as a write to the wrong register. Every output is therefore compared after every strobe against a model that applies the same frame. Frames with invalid addresses, and clock pulses given while the strobe is high, are placed so that a fault would alter an output within a few cycles of the next strobe.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  parameter int FRAME_W = 21;
  parameter int ADR_W   = 4;
  parameter int MAIN_W  = 17;
  parameter int REF_W   = 12;

  localparam int CNT_W = $clog2(FRAME_W + 1);

  typedef enum logic [ADR_W-1:0] {
    ADR_CTRL  = 4'd0,
    ADR_MAIN1 = 4'd1,
    ADR_REF   = 4'd2,
    ADR_MAIN2 = 4'd3
  } adr_e;

  localparam logic [MAIN_W-1:0] MAIN_RST = MAIN_W'(1024);
  localparam logic [REF_W-1:0]  REF_RST  = REF_W'(6);

  // Field positions inside the frame.
  localparam int PIN_LSB  = ADR_W;
  localparam int LOCK_LSB = ADR_W + 4;
  localparam int CP_LSB   = ADR_W + 6;
  localparam int RUN_LSB  = ADR_W + 8;
  localparam int RSEL_BIT = ADR_W + REF_W;
  localparam int TEST_BIT = ADR_W + REF_W + 1;
endpackage

// File: rtl/serprog_sync.sv
module serprog_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] stg [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      prev_q <= '0;
    end else begin
      stg[0] <= in_i;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      prev_q <= stg[STAGES-1];
    end
  end

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~prev_q;
endmodule

// File: rtl/serprog_frame.sv
module serprog_frame
  import serprog_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_i,
  input  logic               sclk_rise_i,
  input  logic               le_lvl_i,
  output logic [FRAME_W-1:0] frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     frame_o <= '0;
    else if (sclk_rise_i && !le_lvl_i) frame_o <= {frame_o[FRAME_W-2:0], data_i};
  end
endmodule

// File: rtl/serprog_bank.sv
module serprog_bank
  import serprog_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [MAIN_W-1:0]  main1_o,
  output logic [MAIN_W-1:0]  main2_o,
  output logic [REF_W-1:0]   ref_div_o,
  output logic               ref_sel_o,
  output logic               test_o,
  output logic [3:0]         pin_o,
  output logic [1:0]         lock_sel_o,
  output logic [1:0]         cp_hi_o,
  output logic [1:0]         run_o
);
  logic [ADR_W-1:0]  adr;
  logic [MAIN_W-1:0] main_fld;

  assign adr      = frame_i[ADR_W-1:0];
  assign main_fld = frame_i[ADR_W +: MAIN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main1_o    <= MAIN_RST;
      main2_o    <= MAIN_RST;
      ref_div_o  <= REF_RST;
      ref_sel_o  <= 1'b0;
      test_o     <= 1'b0;
      pin_o      <= '0;
      lock_sel_o <= '0;
      cp_hi_o    <= '0;
      run_o      <= '0;
    end else if (load_i) begin
      case (adr)
        ADR_CTRL: begin
          pin_o      <= frame_i[PIN_LSB  +: 4];
          lock_sel_o <= frame_i[LOCK_LSB +: 2];
          cp_hi_o    <= frame_i[CP_LSB   +: 2];
          run_o      <= frame_i[RUN_LSB  +: 2];
        end
        ADR_MAIN1: main1_o <= main_fld;
        ADR_MAIN2: main2_o <= main_fld;
        ADR_REF: begin
          ref_div_o <= frame_i[ADR_W +: REF_W];
          ref_sel_o <= frame_i[RSEL_BIT];
          test_o    <= frame_i[TEST_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/serprog_top.sv
module serprog_top
  import serprog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              sload_i,
  output logic [MAIN_W-1:0] main1_o,
  output logic [MAIN_W-1:0] main2_o,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              ref_sel_o,
  output logic              test_o,
  output logic [3:0]        pin_o,
  output logic [1:0]        lock_sel_o,
  output logic [1:0]        cp_hi_o,
  output logic [1:0]        run_o
);
  logic [2:0]         lvl, rise;
  logic [FRAME_W-1:0] frame_q;
  logic               load_stb;

  serprog_sync #(.N(3), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  ({sload_i, sclk_i, sdata_i}),
    .lvl_o (lvl),
    .rise_o(rise)
  );

  assign load_stb = rise[2];

  serprog_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (lvl[0]),
    .sclk_rise_i(rise[1]),
    .le_lvl_i   (lvl[2]),
    .frame_o    (frame_q)
  );

  serprog_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load_stb),
    .frame_i   (frame_q),
    .main1_o   (main1_o),
    .main2_o   (main2_o),
    .ref_div_o (ref_div_o),
    .ref_sel_o (ref_sel_o),
    .test_o    (test_o),
    .pin_o     (pin_o),
    .lock_sel_o(lock_sel_o),
    .cp_hi_o   (cp_hi_o),
    .run_o     (run_o)
  );
endmodule

// File: rtl/serprog_chk.sv
module serprog_chk
  import serprog_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_stb,
  input logic [2:0]         lvl,
  input logic [FRAME_W-1:0] frame_q,
  input logic [MAIN_W-1:0]  main1_o,
  input logic [MAIN_W-1:0]  main2_o,
  input logic [REF_W-1:0]   ref_div_o,
  input logic               ref_sel_o,
  input logic               test_o,
  input logic [3:0]         pin_o,
  input logic [1:0]         lock_sel_o,
  input logic [1:0]         cp_hi_o,
  input logic [1:0]         run_o
);
  logic [ADR_W-1:0] adr;
  assign adr = frame_q[ADR_W-1:0];

  a_r3_ctrl_on_addr0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({pin_o, lock_sel_o, cp_hi_o, run_o}) |-> $past(load_stb) && $past(adr) == 4'd0);

  a_r4_main1_on_addr1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(main1_o) |-> $past(load_stb) && $past(adr) == 4'd1);

  a_r5_main2_on_addr3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(main2_o) |-> $past(load_stb) && $past(adr) == 4'd3);

  a_r6_ref_on_addr2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ref_div_o, ref_sel_o, test_o}) |-> $past(load_stb) && $past(adr) == 4'd2);

  a_r7_bad_addr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(load_stb) && $past(adr) > 4'd3 |->
      $stable({main1_o, main2_o, ref_div_o, ref_sel_o, test_o, pin_o, lock_sel_o, cp_hi_o, run_o}));

  a_r9_no_shift_le_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lvl[2]) |-> $stable(frame_q));
endmodule

bind serprog_top serprog_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_stb  (load_stb),
  .lvl       (lvl),
  .frame_q   (frame_q),
  .main1_o   (main1_o),
  .main2_o   (main2_o),
  .ref_div_o (ref_div_o),
  .ref_sel_o (ref_sel_o),
  .test_o    (test_o),
  .pin_o     (pin_o),
  .lock_sel_o(lock_sel_o),
  .cp_hi_o   (cp_hi_o),
  .run_o     (run_o)
);

// File: tb/sim_serprog_top.sv
`timescale 1ns/1ps
module sim_serprog_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b0, sload = 1'b0;
  logic [16:0] main1, main2;
  logic [11:0] ref_div;
  logic ref_sel, test_b;
  logic [3:0] pin;
  logic [1:0] lock_sel, cp_hi, run;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [16:0] e_main1 = 17'd1024, e_main2 = 17'd1024;
  logic [11:0] e_ref = 12'd6;
  logic e_rsel = 0, e_test = 0;
  logic [3:0] e_pin = 0;
  logic [1:0] e_lock = 0, e_cp = 0, e_run = 0;

  always #2.5 clk = ~clk;

  serprog_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .sload_i(sload),
    .main1_o(main1), .main2_o(main2), .ref_div_o(ref_div), .ref_sel_o(ref_sel),
    .test_o(test_b), .pin_o(pin), .lock_sel_o(lock_sel), .cp_hi_o(cp_hi), .run_o(run)
  );

  function automatic logic [20:0] mk(input logic [16:0] body, input logic [3:0] adr);
    return {body, adr};
  endfunction

  task automatic model_write(input logic [20:0] f);
    case (f[3:0])
      4'd0: begin e_pin = f[7:4]; e_lock = f[9:8]; e_cp = f[11:10]; e_run = f[13:12]; end
      4'd1: e_main1 = f[20:4];
      4'd3: e_main2 = f[20:4];
      4'd2: begin e_ref = f[15:4]; e_rsel = f[16]; e_test = f[17]; end
      default: ;
    endcase
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sbit(input logic b);
    sdata = b; ticks(4); sclk = 1'b1; ticks(4); sclk = 1'b0;
  endtask

  task automatic shift_frame(input logic [20:0] f);
    for (int i = 20; i >= 0; i--) sbit(f[i]);
    ticks(4);
  endtask

  task automatic strobe();
    sload = 1'b1; ticks(8); sload = 1'b0; ticks(8);
  endtask

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    cmp({tag, " main1"}, 64'(main1), 64'(e_main1));
    cmp({tag, " main2"}, 64'(main2), 64'(e_main2));
    cmp({tag, " ref"}, 64'({ref_div, ref_sel, test_b}), 64'({e_ref, e_rsel, e_test}));
    cmp({tag, " ctrl"}, 64'({pin, lock_sel, cp_hi, run}), 64'({e_pin, e_lock, e_cp, e_run}));
  endtask

  task automatic write(input logic [20:0] f, input string tag);
    shift_frame(f); strobe(); model_write(f); check_all(tag);
  endtask

  initial begin
    logic [20:0] f;
    void'($urandom(32'd4711));
    ticks(3);
    check_all("R1 reset");
    rst_n = 1'b1;
    ticks(4);
    check_all("R1 after release");

    // directed layouts
    write(mk(17'h1_2345, 4'd1), "R4 main1 R2");
    write(mk(17'h0_BCDE, 4'd3), "R5 main2");
    write(mk({3'b101, 1'b1, 1'b1, 12'hA5C}, 4'd2), "R6 ref");
    write(mk({7'h7F, 2'b01, 2'b10, 2'b11, 4'b1001}, 4'd0), "R3 ctrl run ch1");
    write(mk({7'h00, 2'b10, 2'b01, 2'b00, 4'b0110}, 4'd0), "R3 ctrl run ch2");
    write(mk(17'h1_FFFF, 4'd1), "R4 main1 max");
    write(mk(17'h1_5555, 4'd7), "R7 bad addr 7");
    write(mk(17'h0_AAAA, 4'd15), "R7 bad addr 15");
    write(mk(17'h0_0F0F, 4'd4), "R7 bad addr 4");

    // R9: clock pulses while strobe high must not shift
    f = mk(17'h0_1357, 4'd1);
    shift_frame(f);
    sload = 1'b1; ticks(8);
    sbit(1'b0); sbit(1'b0); sbit(1'b0); sbit(1'b1);
    ticks(4); sload = 1'b0; ticks(8);
    model_write(f);
    check_all("R9 first");
    strobe();
    check_all("R9 R8 restrobe");

    // R8: no strobe, no write
    shift_frame(mk(17'h0_0400, 4'd3));
    ticks(10);
    check_all("R8 no strobe");
    strobe();
    model_write(mk(17'h0_0400, 4'd3));
    check_all("R8 strobe");

    for (int k = 0; k < 40; k++) begin
      f = 21'($urandom());
      write(f, "R8 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        ticks(150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule